// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block drives one logical AUX transfer through a separate transaction engine and decides, after each attempt, whether to retry, pause, pass or fail. It launches an attempt by raising a request toward the engine and holding it until the engine acknowledges. With the acknowledge the engine supplies an outcome status, a reply code and a returned byte count. The controller classifies that outcome and updates a set of per-cause retry budgets, which count short reads, native defers, I2C defers, timeouts and invalid replies. It also keeps an accumulated defer time in milliseconds and a sticky flag that records whether any defer has been seen. An internal delay timer produces the microsecond and millisecond pauses between attempts.

A caller presents the direction, the requested byte count, the per-defer polling timeout and the defer delay, then pulses start while the block is idle. The caller waits for a one-cycle done pulse, then reads the pass/fail flag and the last reply code.

Top module: `aux_retry_ctrl`

## Requirements
- R1: A transfer makes at most MAX_ATTEMPTS engine attempts (default 7). If the outcome of the last allowed attempt would otherwise cause a retry, the transfer fails instead.
- R2: `eng_req_o` rises in the cycle after an accepted start, or after a pause ends. It stays high until `eng_ack_i` is sampled high, and status, reply and byte count are sampled in that same cycle. The request is low for one evaluation cycle plus any pause before the next attempt.
- R3: Status OK is 0 and reply ACK is 0x0. An ACK on a write, or on a read whose byte count equals the requested length, passes. An ACK on a read whose byte count differs from the requested length retries after ACK_WAIT_US µs. The seventh such short read fails.
- R4: Reply 0x2 (native defer) adds the polling timeout to the defer time and increments the defer count. Both 0x2 and reply 0x8 (bridged-I2C defer) set the sticky defer-seen flag.
- R5: After reply 0x2, 0x8 or 0x4 (bridged-I2C NACK) has been processed, the transfer fails if the defer count is at least 7 and the defer time is at least 50 ms. Otherwise 0x2 and 0x8 pause for the defer delay in ms and add it to the defer time, and 0x4 retries at once.
- R6: Reply 0xC (I2C target defer) clears the defer count, increments the I2C-defer count and retries at once. The seventh such reply fails.
- R7: Reply 0x1 (native NACK), any reply code not named in R3 to R6, and status 3 (disconnect), 4 (engine not acquired) or 5 to 7 (unknown) fail immediately. `done_o` is high with `pass_o` low in the second cycle after the acknowledge.
- R8: Status 1 (invalid reply) fails on its second occurrence. Otherwise it retries after INVALID_WAIT_US µs.
- R9: Status 2 (timeout) after a defer has been seen counts as a defer, fails once that count reaches 7, and otherwise pauses for the defer delay. Without a prior defer, the third counted timeout fails and a retry follows with no pause.
- R10: Any attempt with status 0 clears the timeout and invalid-reply counts.
- R11: `done_o` is a one-cycle pulse issued while idle. `pass_o` and `reply_o` (the last reply code) hold until the next transfer ends. Start is ignored while busy. Start clears all counts, the defer time and the defer-seen flag. After reset the block is idle with `done_o`, `pass_o` and `eng_req_o` low.
- R12: A pause of N µs lasts N×CLK_PER_US cycles. A pause of N ms lasts N×US_PER_MS×CLK_PER_US cycles. A zero-length pause is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a transfer (taken only when idle) |
| is_write_i | input | 1 | Transfer direction, 1 = write |
| req_len_i | input | LEN_W | Requested byte count |
| poll_ms_i | input | DLY_W | Polling timeout in ms added per native defer |
| defer_ms_i | input | DLY_W | Defer pause length in ms |
| idle_o | output | 1 | Controller idle |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the last transfer |
| reply_o | output | 4 | Reply code of the final attempt |
| eng_req_o | output | 1 | Attempt request to the engine |
| eng_ack_i | input | 1 | Engine outcome valid |
| eng_status_i | input | 3 | Engine outcome status |
| eng_reply_i | input | 4 | Reply code from the sink |
| eng_bytes_i | input | LEN_W | Data bytes returned |

## Verification
Most wrong internal states show up at the request pin. A counter that was not cleared, or was cleared at the wrong time, changes the number of request pulses. A wrong pause length moves the next request rise by a whole number of microseconds or milliseconds. A wrongly set defer-seen flag turns an immediate timeout retry into a delayed one, visible at the very next request. Because the outputs are compared with a behavioural model on every clock, such an error is reported in the first cycle where the request, idle, done, pass or reply pins diverge, usually within one attempt.

// File: rtl/aux_retry_pkg.sv
// Shared codes and state types for the AUX retry controller.
// Assumes a 3-bit engine status and a 4-bit sink reply code.
package aux_retry_pkg;

    localparam logic [2:0] ST_OK      = 3'd0;
    localparam logic [2:0] ST_INVALID = 3'd1;
    localparam logic [2:0] ST_TIMEOUT = 3'd2;
    localparam logic [2:0] ST_DISCON  = 3'd3;
    localparam logic [2:0] ST_NOENG   = 3'd4;

    localparam logic [3:0] RP_ACK       = 4'h0;
    localparam logic [3:0] RP_NACK      = 4'h1;
    localparam logic [3:0] RP_DEFER     = 4'h2;
    localparam logic [3:0] RP_BR_NACK   = 4'h4;
    localparam logic [3:0] RP_BR_DEFER  = 4'h8;
    localparam logic [3:0] RP_I2C_DEFER = 4'hC;

    typedef enum logic [1:0] {
        ACT_PASS,
        ACT_FAIL,
        ACT_RETRY
    } verdict_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ISSUE,
        FS_EVAL,
        FS_PAUSE
    } fsm_e;

endpackage

// File: rtl/aux_retry_timer.sv
// Pause timer: loads a length in microseconds or milliseconds and flags
// the last cycle of the pause. Assumes amt_i is non-zero when loaded.
module aux_retry_timer #(
    parameter int CLK_PER_US = 50,
    parameter int US_PER_MS  = 1000,
    parameter int AMT_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             unit_ms_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic             last_o
);
    localparam int MS_CYC = CLK_PER_US * US_PER_MS;
    localparam int TMR_W  = AMT_W + $clog2(MS_CYC + 1);

    logic [TMR_W-1:0] scale;
    logic [TMR_W-1:0] remain;

    // Pick the cycles-per-unit factor for the requested unit.
    always_comb begin
        scale = unit_ms_i ? TMR_W'(MS_CYC) : TMR_W'(CLK_PER_US);
    end

    // Count the pause down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load_i) begin
            remain <= TMR_W'(amt_i) * scale;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign last_o = (remain == TMR_W'(1));

endmodule

// File: rtl/aux_retry_classify.sv
// Outcome classifier: from one attempt's status, reply and byte count
// plus the current budgets, computes the verdict, the pause and the
// updated budgets. Purely combinational; the attempt cap is applied above.
module aux_retry_classify
    import aux_retry_pkg::*;
#(
    parameter int CNT_W           = 3,
    parameter int LEN_W           = 5,
    parameter int DLY_W           = 8,
    parameter int DTIME_W         = 10,
    parameter int AMT_W           = 9,
    parameter int ACK_LIMIT       = 7,
    parameter int DEFER_LIMIT     = 7,
    parameter int I2C_DEFER_LIMIT = 7,
    parameter int INVALID_LIMIT   = 2,
    parameter int TIMEOUT_LIMIT   = 3,
    parameter int DEFER_TIME_MS   = 50,
    parameter int ACK_WAIT_US     = 300,
    parameter int INVALID_WAIT_US = 400
) (
    input  logic [2:0]         status_i,
    input  logic [3:0]         reply_i,
    input  logic [LEN_W-1:0]   bytes_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               is_write_i,
    input  logic [DLY_W-1:0]   poll_ms_i,
    input  logic [DLY_W-1:0]   defer_ms_i,
    input  logic [CNT_W-1:0]   ack_cnt_i,
    input  logic [CNT_W-1:0]   def_cnt_i,
    input  logic [CNT_W-1:0]   i2c_cnt_i,
    input  logic [CNT_W-1:0]   to_cnt_i,
    input  logic [CNT_W-1:0]   inv_cnt_i,
    input  logic [DTIME_W-1:0] dtime_i,
    input  logic               seen_i,
    output logic [CNT_W-1:0]   ack_cnt_o,
    output logic [CNT_W-1:0]   def_cnt_o,
    output logic [CNT_W-1:0]   i2c_cnt_o,
    output logic [CNT_W-1:0]   to_cnt_o,
    output logic [CNT_W-1:0]   inv_cnt_o,
    output logic [DTIME_W-1:0] dtime_o,
    output logic               seen_o,
    output verdict_e           verdict_o,
    output logic               wait_ms_o,
    output logic [AMT_W-1:0]   wait_amt_o
);
    // Saturating add of a millisecond amount into the defer time.
    function automatic logic [DTIME_W-1:0] add_ms(input logic [DTIME_W-1:0] base,
                                                  input logic [DLY_W-1:0]   inc);
        logic [DTIME_W:0] sum;
        sum = {1'b0, base} + {{(DTIME_W + 1 - DLY_W){1'b0}}, inc};
        return sum[DTIME_W] ? {DTIME_W{1'b1}} : sum[DTIME_W-1:0];
    endfunction

    logic defer_like;
    logic exit_now;

    assign defer_like = (reply_i == RP_DEFER) || (reply_i == RP_BR_DEFER);

    // Decide the verdict and the next budgets for the captured outcome.
    always_comb begin
        ack_cnt_o  = ack_cnt_i;
        def_cnt_o  = def_cnt_i;
        i2c_cnt_o  = i2c_cnt_i;
        to_cnt_o   = to_cnt_i;
        inv_cnt_o  = inv_cnt_i;
        dtime_o    = dtime_i;
        seen_o     = seen_i;
        verdict_o  = ACT_FAIL;
        wait_ms_o  = 1'b0;
        wait_amt_o = '0;
        exit_now   = 1'b0;
        case (status_i)
            ST_OK: begin
                to_cnt_o  = '0;
                inv_cnt_o = '0;
                if (reply_i == RP_ACK) begin
                    if (!is_write_i && (bytes_i != len_i)) begin
                        ack_cnt_o = ack_cnt_i + 1'b1;
                        if (ack_cnt_o >= CNT_W'(ACK_LIMIT)) begin
                            verdict_o = ACT_FAIL;
                        end else begin
                            verdict_o  = ACT_RETRY;
                            wait_amt_o = AMT_W'(ACK_WAIT_US);
                        end
                    end else begin
                        verdict_o = ACT_PASS;
                    end
                end else if (defer_like || (reply_i == RP_BR_NACK)) begin
                    if (reply_i == RP_DEFER) begin
                        dtime_o   = add_ms(dtime_i, poll_ms_i);
                        def_cnt_o = def_cnt_i + 1'b1;
                    end
                    if (defer_like) begin
                        seen_o = 1'b1;
                    end
                    exit_now = (def_cnt_o >= CNT_W'(DEFER_LIMIT)) &&
                               (dtime_o >= DTIME_W'(DEFER_TIME_MS));
                    if (exit_now) begin
                        verdict_o = ACT_FAIL;
                    end else begin
                        verdict_o = ACT_RETRY;
                        if (defer_like) begin
                            wait_ms_o  = 1'b1;
                            wait_amt_o = AMT_W'(defer_ms_i);
                            dtime_o    = add_ms(dtime_o, defer_ms_i);
                        end
                    end
                end else if (reply_i == RP_I2C_DEFER) begin
                    def_cnt_o = '0;
                    i2c_cnt_o = i2c_cnt_i + 1'b1;
                    verdict_o = (i2c_cnt_o >= CNT_W'(I2C_DEFER_LIMIT)) ? ACT_FAIL : ACT_RETRY;
                end else begin
                    verdict_o = ACT_FAIL;
                end
            end
            ST_INVALID: begin
                inv_cnt_o = inv_cnt_i + 1'b1;
                if (inv_cnt_o >= CNT_W'(INVALID_LIMIT)) begin
                    verdict_o = ACT_FAIL;
                end else begin
                    verdict_o  = ACT_RETRY;
                    wait_amt_o = AMT_W'(INVALID_WAIT_US);
                end
            end
            ST_TIMEOUT: begin
                if (seen_i) begin
                    def_cnt_o = def_cnt_i + 1'b1;
                    if (def_cnt_o >= CNT_W'(DEFER_LIMIT)) begin
                        verdict_o = ACT_FAIL;
                    end else begin
                        verdict_o  = ACT_RETRY;
                        wait_ms_o  = 1'b1;
                        wait_amt_o = AMT_W'(defer_ms_i);
                    end
                end else begin
                    to_cnt_o  = to_cnt_i + 1'b1;
                    verdict_o = (to_cnt_o >= CNT_W'(TIMEOUT_LIMIT)) ? ACT_FAIL : ACT_RETRY;
                end
            end
            default: verdict_o = ACT_FAIL;
        endcase
    end

endmodule

// File: rtl/aux_retry_ctrl.sv
// AUX retry controller top: sequences attempts through the engine
// handshake, applies the attempt cap, runs pauses and reports the result.
// Assumes the engine holds its outcome valid in the cycle eng_ack_i is high.
module aux_retry_ctrl
    import aux_retry_pkg::*;
#(
    parameter int MAX_ATTEMPTS    = 7,
    parameter int ACK_LIMIT       = 7,
    parameter int DEFER_LIMIT     = 7,
    parameter int I2C_DEFER_LIMIT = 7,
    parameter int INVALID_LIMIT   = 2,
    parameter int TIMEOUT_LIMIT   = 3,
    parameter int DEFER_TIME_MS   = 50,
    parameter int ACK_WAIT_US     = 300,
    parameter int INVALID_WAIT_US = 400,
    parameter int CLK_PER_US      = 50,
    parameter int US_PER_MS       = 1000,
    parameter int LEN_W           = 5,
    parameter int DLY_W           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_write_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic [DLY_W-1:0] poll_ms_i,
    input  logic [DLY_W-1:0] defer_ms_i,
    output logic             idle_o,
    output logic             done_o,
    output logic             pass_o,
    output logic [3:0]       reply_o,
    output logic             eng_req_o,
    input  logic             eng_ack_i,
    input  logic [2:0]       eng_status_i,
    input  logic [3:0]       eng_reply_i,
    input  logic [LEN_W-1:0] eng_bytes_i
);
    localparam int CNT_W   = $clog2(MAX_ATTEMPTS + 1);
    localparam int DTIME_W = DLY_W + 2;
    localparam int US_MAX  = (ACK_WAIT_US > INVALID_WAIT_US) ? ACK_WAIT_US : INVALID_WAIT_US;
    localparam int US_W    = $clog2(US_MAX + 1);
    localparam int AMT_W   = (US_W > DLY_W) ? US_W : DLY_W;

    fsm_e               state;
    logic [CNT_W-1:0]   attempts;
    logic [CNT_W-1:0]   ack_cnt, def_cnt, i2c_cnt, to_cnt, inv_cnt;
    logic [DTIME_W-1:0] dtime;
    logic               seen;
    logic [2:0]         cap_status;
    logic [3:0]         cap_reply;
    logic [LEN_W-1:0]   cap_bytes;
    logic               lat_write;
    logic [LEN_W-1:0]   lat_len;
    logic [DLY_W-1:0]   lat_poll;
    logic [DLY_W-1:0]   lat_defer;
    logic               done_q, pass_q;
    logic [3:0]         reply_q;

    logic [CNT_W-1:0]   n_ack, n_def, n_i2c, n_to, n_inv;
    logic [DTIME_W-1:0] n_dtime;
    logic               n_seen;
    verdict_e           verdict;
    logic               wait_ms;
    logic [AMT_W-1:0]   wait_amt;
    logic               cap_hit;
    logic               finish;
    logic               tmr_load;
    logic               tmr_last;

    aux_retry_classify #(
        .CNT_W           (CNT_W),
        .LEN_W           (LEN_W),
        .DLY_W           (DLY_W),
        .DTIME_W         (DTIME_W),
        .AMT_W           (AMT_W),
        .ACK_LIMIT       (ACK_LIMIT),
        .DEFER_LIMIT     (DEFER_LIMIT),
        .I2C_DEFER_LIMIT (I2C_DEFER_LIMIT),
        .INVALID_LIMIT   (INVALID_LIMIT),
        .TIMEOUT_LIMIT   (TIMEOUT_LIMIT),
        .DEFER_TIME_MS   (DEFER_TIME_MS),
        .ACK_WAIT_US     (ACK_WAIT_US),
        .INVALID_WAIT_US (INVALID_WAIT_US)
    ) u_classify (
        .status_i   (cap_status),
        .reply_i    (cap_reply),
        .bytes_i    (cap_bytes),
        .len_i      (lat_len),
        .is_write_i (lat_write),
        .poll_ms_i  (lat_poll),
        .defer_ms_i (lat_defer),
        .ack_cnt_i  (ack_cnt),
        .def_cnt_i  (def_cnt),
        .i2c_cnt_i  (i2c_cnt),
        .to_cnt_i   (to_cnt),
        .inv_cnt_i  (inv_cnt),
        .dtime_i    (dtime),
        .seen_i     (seen),
        .ack_cnt_o  (n_ack),
        .def_cnt_o  (n_def),
        .i2c_cnt_o  (n_i2c),
        .to_cnt_o   (n_to),
        .inv_cnt_o  (n_inv),
        .dtime_o    (n_dtime),
        .seen_o     (n_seen),
        .verdict_o  (verdict),
        .wait_ms_o  (wait_ms),
        .wait_amt_o (wait_amt)
    );

    aux_retry_timer #(
        .CLK_PER_US (CLK_PER_US),
        .US_PER_MS  (US_PER_MS),
        .AMT_W      (AMT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .unit_ms_i (wait_ms),
        .amt_i     (wait_amt),
        .last_o    (tmr_last)
    );

    // Attempt cap and end-of-transfer decision for the evaluation cycle.
    always_comb begin
        cap_hit  = (attempts >= CNT_W'(MAX_ATTEMPTS));
        finish   = (verdict != ACT_RETRY) || cap_hit;
        tmr_load = (state == FS_EVAL) && !finish && (wait_amt != '0);
    end

    // Sequencer: start, issue, evaluate, pause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FS_IDLE;
            attempts   <= '0;
            ack_cnt    <= '0;
            def_cnt    <= '0;
            i2c_cnt    <= '0;
            to_cnt     <= '0;
            inv_cnt    <= '0;
            dtime      <= '0;
            seen       <= 1'b0;
            cap_status <= '0;
            cap_reply  <= '0;
            cap_bytes  <= '0;
            lat_write  <= 1'b0;
            lat_len    <= '0;
            lat_poll   <= '0;
            lat_defer  <= '0;
            done_q     <= 1'b0;
            pass_q     <= 1'b0;
            reply_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                FS_IDLE: begin
                    if (start_i) begin
                        attempts  <= '0;
                        ack_cnt   <= '0;
                        def_cnt   <= '0;
                        i2c_cnt   <= '0;
                        to_cnt    <= '0;
                        inv_cnt   <= '0;
                        dtime     <= '0;
                        seen      <= 1'b0;
                        lat_write <= is_write_i;
                        lat_len   <= req_len_i;
                        lat_poll  <= poll_ms_i;
                        lat_defer <= defer_ms_i;
                        state     <= FS_ISSUE;
                    end
                end
                FS_ISSUE: begin
                    if (eng_ack_i) begin
                        cap_status <= eng_status_i;
                        cap_reply  <= eng_reply_i;
                        cap_bytes  <= eng_bytes_i;
                        attempts   <= attempts + 1'b1;
                        state      <= FS_EVAL;
                    end
                end
                FS_EVAL: begin
                    ack_cnt <= n_ack;
                    def_cnt <= n_def;
                    i2c_cnt <= n_i2c;
                    to_cnt  <= n_to;
                    inv_cnt <= n_inv;
                    dtime   <= n_dtime;
                    seen    <= n_seen;
                    if (finish) begin
                        done_q  <= 1'b1;
                        pass_q  <= (verdict == ACT_PASS);
                        reply_q <= cap_reply;
                        state   <= FS_IDLE;
                    end else if (wait_amt != '0) begin
                        state <= FS_PAUSE;
                    end else begin
                        state <= FS_ISSUE;
                    end
                end
                FS_PAUSE: begin
                    if (tmr_last) begin
                        state <= FS_ISSUE;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign idle_o    = (state == FS_IDLE);
    assign eng_req_o = (state == FS_ISSUE);
    assign done_o    = done_q;
    assign pass_o    = pass_q;
    assign reply_o   = reply_q;

endmodule

// File: rtl/aux_retry_ctrl_chk.sv
// Port-level property checker for aux_retry_ctrl, attached by bind.
// Assumes it sees the top's ports under their own names.
module aux_retry_ctrl_chk
    import aux_retry_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       idle_o,
    input logic       done_o,
    input logic       pass_o,
    input logic       eng_req_o,
    input logic       eng_ack_i,
    input logic [2:0] eng_status_i
);
    int   att;
    logic req_q;

    // Count request rises since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att   <= 0;
            req_q <= 1'b0;
        end else begin
            req_q <= eng_req_o;
            if (start_i && idle_o) begin
                att <= 0;
            end else if (eng_req_o && !req_q) begin
                att <= att + 1;
            end
        end
    end

    a_r1_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        att <= MAX_ATTEMPTS);

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && !eng_ack_i) |=> eng_req_o);

    a_r2_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && eng_ack_i) |=> !eng_req_o);

    a_r7_discon_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && eng_ack_i && (eng_status_i == ST_DISCON)) |=> ##1 (done_o && !pass_o));

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (idle_o && !eng_req_o));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind aux_retry_ctrl aux_retry_ctrl_chk #(
    .MAX_ATTEMPTS (MAX_ATTEMPTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .idle_o       (idle_o),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .eng_req_o    (eng_req_o),
    .eng_ack_i    (eng_ack_i),
    .eng_status_i (eng_status_i)
);

// File: tb/aux_retry_ctrl_bench.sv
// Bench: scripted engine, behavioural per-clock model, scenario checks.
module aux_retry_ctrl_bench;
    localparam int MAXA  = 10;
    localparam int CPU   = 1;
    localparam int UPM   = 4;
    localparam int MSC   = CPU * UPM;
    localparam int LEN_W = 5;
    localparam int DLY_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             is_write_i = 1'b0;
    logic [LEN_W-1:0] req_len_i = '0;
    logic [DLY_W-1:0] poll_ms_i = '0;
    logic [DLY_W-1:0] defer_ms_i = '0;
    logic             idle_o, done_o, pass_o, eng_req_o;
    logic [3:0]       reply_o;
    logic             eng_ack_i = 1'b0;
    logic [2:0]       eng_status_i = '0;
    logic [3:0]       eng_reply_i = '0;
    logic [LEN_W-1:0] eng_bytes_i = '0;

    aux_retry_ctrl #(
        .MAX_ATTEMPTS (MAXA),
        .CLK_PER_US   (CPU),
        .US_PER_MS    (UPM),
        .LEN_W        (LEN_W),
        .DLY_W        (DLY_W)
    ) u_aux_retry_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .is_write_i   (is_write_i),
        .req_len_i    (req_len_i),
        .poll_ms_i    (poll_ms_i),
        .defer_ms_i   (defer_ms_i),
        .idle_o       (idle_o),
        .done_o       (done_o),
        .pass_o       (pass_o),
        .reply_o      (reply_o),
        .eng_req_o    (eng_req_o),
        .eng_ack_i    (eng_ack_i),
        .eng_status_i (eng_status_i),
        .eng_reply_i  (eng_reply_i),
        .eng_bytes_i  (eng_bytes_i)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int q_st[$];
    int q_rp[$];
    int q_by[$];
    int att_seen = 0;
    int wait_c = 0;
    bit prev_req = 1'b0;

    // Behavioural reference model state.
    int m_ph = 0, m_w = 0, m_att = 0;
    bit m_done = 0, m_pass = 0;
    int m_reply = 0;
    int c_ack, c_def, c_i2c, c_to, c_inv, c_time;
    bit seen;
    int m_len, m_poll, m_dly;
    bit m_wr;
    int k_st, k_rp, k_by, v, wcyc;
    bit model_on = 0;

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int x);
        return (x > 1023) ? 1023 : x;
    endfunction

    // Reference model: advances on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_done = 0; m_pass = 0; m_reply = 0; m_att = 0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: if (start_i) begin
                    m_att = 0; c_ack = 0; c_def = 0; c_i2c = 0; c_to = 0; c_inv = 0;
                    c_time = 0; seen = 0;
                    m_len = int'(req_len_i); m_wr = is_write_i;
                    m_poll = int'(poll_ms_i); m_dly = int'(defer_ms_i);
                    m_ph = 1;
                end
                1: if (eng_ack_i) begin
                    k_st = int'(eng_status_i); k_rp = int'(eng_reply_i); k_by = int'(eng_bytes_i);
                    m_att++;
                    m_ph = 2;
                end
                2: begin
                    wcyc = 0;
                    if (k_st == 0) begin
                        c_to = 0; c_inv = 0;
                        if (k_rp == 0) begin
                            if (!m_wr && k_by != m_len) begin
                                c_ack++;
                                if (c_ack >= 7) v = 0; else begin v = 2; wcyc = 300 * CPU; end
                            end else v = 1;
                        end else if (k_rp == 2 || k_rp == 8 || k_rp == 4) begin
                            if (k_rp == 2) begin c_time = sat(c_time + m_poll); c_def++; end
                            if (k_rp != 4) seen = 1;
                            if (c_def >= 7 && c_time >= 50) v = 0;
                            else begin
                                v = 2;
                                if (k_rp != 4) begin wcyc = m_dly * MSC; c_time = sat(c_time + m_dly); end
                            end
                        end else if (k_rp == 12) begin
                            c_def = 0; c_i2c++;
                            v = (c_i2c >= 7) ? 0 : 2;
                        end else v = 0;
                    end else if (k_st == 1) begin
                        c_inv++;
                        if (c_inv >= 2) v = 0; else begin v = 2; wcyc = 400 * CPU; end
                    end else if (k_st == 2) begin
                        if (seen) begin
                            c_def++;
                            if (c_def >= 7) v = 0; else begin v = 2; wcyc = m_dly * MSC; end
                        end else begin
                            c_to++;
                            v = (c_to >= 3) ? 0 : 2;
                        end
                    end else v = 0;
                    if (v == 2 && m_att >= MAXA) v = 0;
                    if (v != 2) begin
                        m_done = 1; m_pass = (v == 1); m_reply = k_rp; m_ph = 0;
                    end else if (wcyc > 0) begin
                        m_w = wcyc; m_ph = 3;
                    end else m_ph = 1;
                end
                default: begin
                    m_w--;
                    if (m_w == 0) m_ph = 1;
                end
            endcase
        end
    end

    // Per-clock comparison of every output against the model (R2 timing).
    always @(negedge clk) begin
        if (model_on) begin
            chk("R2 req", eng_req_o == (m_ph == 1), int'(eng_req_o), int'(m_ph == 1));
            chk("R11 idle", idle_o == (m_ph == 0), int'(idle_o), int'(m_ph == 0));
            chk("R11 done", done_o == m_done, int'(done_o), int'(m_done));
            chk("R11 pass", pass_o == m_pass, int'(pass_o), int'(m_pass));
            chk("R11 reply", int'(reply_o) == m_reply, int'(reply_o), m_reply);
        end
    end

    // Scripted engine: acknowledges on the second cycle of each request.
    always @(negedge clk) begin
        eng_ack_i <= 1'b0;
        if (eng_req_o) begin
            if (!prev_req) att_seen++;
            wait_c++;
            if (wait_c == 2) begin
                wait_c = 0;
                if (q_st.size() > 0) begin
                    eng_status_i <= 3'(q_st.pop_front());
                    eng_reply_i  <= 4'(q_rp.pop_front());
                    eng_bytes_i  <= LEN_W'(q_by.pop_front());
                end else begin
                    eng_status_i <= 3'd4;
                    eng_reply_i  <= 4'd0;
                    eng_bytes_i  <= '0;
                end
                eng_ack_i <= 1'b1;
            end
        end else begin
            wait_c = 0;
        end
        prev_req = eng_req_o;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(negedge clk) begin
        cyc++;
        if (cyc >= 200000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic push(input int st, input int rp, input int by, input int n);
        for (int i = 0; i < n; i++) begin
            q_st.push_back(st); q_rp.push_back(rp); q_by.push_back(by);
        end
    endtask

    task automatic run(input string tag, input bit wr, input int len, input int poll,
                       input int dly, input bit poke, input bit exp_pass,
                       input int exp_reply, input int exp_att);
        int cnt;
        @(negedge clk);
        is_write_i = wr; req_len_i = LEN_W'(len);
        poll_ms_i = DLY_W'(poll); defer_ms_i = DLY_W'(dly);
        att_seen = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0;
        while (!done_o) begin
            @(negedge clk);
            cnt++;
            start_i = (poke && cnt == 5);
        end
        start_i = 1'b0;
        chk({tag, " pass"}, pass_o == exp_pass, int'(pass_o), int'(exp_pass));
        chk({tag, " reply"}, int'(reply_o) == exp_reply, int'(reply_o), exp_reply);
        chk({tag, " attempts"}, att_seen == exp_att, att_seen, exp_att);
        repeat (3) @(negedge clk);
        chk({tag, " held"}, pass_o == exp_pass, int'(pass_o), int'(exp_pass));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        chk("R11 reset idle", idle_o == 1'b1, int'(idle_o), 1);
        chk("R11 reset req", eng_req_o == 1'b0, int'(eng_req_o), 0);
        chk("R11 reset done", done_o == 1'b0 && pass_o == 1'b0, int'(done_o), 0);

        // R3 write ACK passes on the first attempt
        push(0, 0, 0, 1);
        run("R3 write ack", 1, 4, 0, 0, 0, 1, 0, 1);
        // R3 short read then full read, 300 us pause (R12)
        push(0, 0, 2, 1); push(0, 0, 4, 1);
        run("R3 short then full", 0, 4, 0, 0, 0, 1, 0, 2);
        // R3 seventh short read fails
        push(0, 0, 1, 7);
        run("R3 seven short", 0, 4, 0, 0, 0, 0, 0, 7);
        // R7 immediate failures
        push(0, 1, 0, 1);
        run("R7 native nack", 1, 2, 0, 0, 0, 0, 1, 1);
        push(3, 0, 0, 1);
        run("R7 disconnect", 1, 2, 0, 0, 0, 0, 0, 1);
        push(6, 0, 0, 1);
        run("R7 unknown status", 1, 2, 0, 0, 0, 0, 0, 1);
        push(0, 3, 0, 1);
        run("R7 unknown reply", 1, 2, 0, 0, 0, 0, 3, 1);
        // R8 invalid twice fails; invalid then ACK passes after 400 us
        push(1, 0, 0, 2);
        run("R8 invalid twice", 1, 2, 0, 0, 0, 0, 0, 2);
        push(1, 0, 0, 1); push(0, 0, 0, 1);
        run("R8 invalid then ack", 1, 2, 0, 0, 0, 1, 0, 2);
        // R11 start while pausing is ignored
        push(1, 0, 0, 1); push(0, 0, 0, 1);
        run("R11 start ignored", 1, 2, 0, 0, 1, 1, 0, 2);
        // R9 third plain timeout fails
        push(2, 0, 0, 3);
        run("R9 three timeouts", 1, 2, 0, 0, 0, 0, 0, 3);
        // R10 OK status clears timeout count
        push(2, 0, 0, 2); push(0, 4, 0, 1); push(2, 0, 0, 2); push(0, 0, 0, 1);
        run("R10 ok clears timeouts", 1, 2, 0, 0, 0, 1, 0, 6);
        // R9 timeouts after a defer count as defers and pause
        push(0, 2, 0, 1); push(2, 0, 0, 3); push(0, 0, 0, 1);
        run("R9 timeout as defer", 1, 2, 1, 1, 0, 1, 0, 5);
        push(0, 2, 0, 1); push(2, 0, 0, 6);
        run("R9 defer limit via timeouts", 1, 2, 1, 0, 0, 0, 0, 7);
        // R4 bridged defer sets the seen flag
        push(0, 8, 0, 1); push(2, 0, 0, 3); push(0, 0, 0, 1);
        run("R4 bridged defer seen", 1, 2, 0, 2, 0, 1, 0, 5);
        // R5 count and time both reached
        push(0, 2, 0, 7);
        run("R5 defer time exit", 1, 2, 8, 0, 0, 0, 2, 7);
        // R1 defer time short: runs to the attempt cap
        push(0, 2, 0, 10);
        run("R1 cap after defers", 1, 2, 1, 1, 0, 0, 2, 10);
        push(0, 4, 0, 10);
        run("R1 cap after bridged nacks", 1, 2, 0, 0, 0, 0, 4, 10);
        // R6 I2C defer clears the defer count; seventh I2C defer fails
        push(0, 2, 0, 6); push(0, 12, 0, 1); push(0, 2, 0, 1); push(0, 0, 0, 1);
        run("R6 clears defer count", 1, 2, 8, 0, 0, 1, 0, 9);
        push(0, 12, 0, 7);
        run("R6 seven i2c defers", 1, 2, 0, 0, 0, 0, 12, 7);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule